// File: doc/BRIEF.md
# Open-Row-First DRAM Command Scheduler

This block sits inside a memory controller between the request side and the DRAM command bus. It keeps a small pool of pending read and write requests, each carrying a transaction ID, a bank, a row and a column. Every cycle it may emit one DRAM command: precharge, activate, read or write. It knows which row is open in every bank, and it uses that knowledge to serve requests whose row is already open before older requests that would force a row change.

Requests to different banks are prepared in an overlapping way. While one bank waits out its precharge or activate delay, another bank can be activated or accessed. A completion carrying the request's ID leaves the block in the same cycle as its read or write command. Requests with different IDs may therefore finish out of arrival order. Requests sharing an ID always finish in the order they arrived. A bypass counter on the oldest request stops a stream of row hits from holding back a row miss forever.

Top module: `rowhit_sched`

## Requirements
- R1: A request whose row is open in its bank, with the activate delay elapsed, is served by a single read or write command, with no precharge or activate in between. Command codes on `cmd_op_o`: 0 precharge, 1 activate, 2 read, 3 write.
- R2: A row miss is served by a precharge (only if another row is open), then an activate of the requested row, then the access. The activate comes at least T_RP cycles after the precharge of that bank. The access comes at least T_RCD cycles after the activate.
- R3: A serviceable row hit is preferred over an older row miss. Among serviceable row hits, the oldest goes first.
- R4: While one bank is waiting on its delay timers, a precharge or activate for a different bank can be issued in the meantime.
- R5: Each read or write command is accompanied in the same cycle by `cpl_valid_o` with the request's ID and direction, and `cpl_valid_o` is never raised in any other cycle. Requests with different IDs may complete out of arrival order.
- R6: Requests with the same ID complete in arrival order, each with its own bank, row, column and direction.
- R7: Once the oldest pending request has been bypassed AGE_MAX times by younger accesses, it is the only request served until it completes.
- R8: After reset the pool is empty, `enq_ready_o` is 1 and no command or completion is issued. When the pool holds DEPTH requests, `enq_ready_o` is 0 and an offered request is not taken.
- R9: Each bank tracks its open row: a precharge is only issued to an open bank, and every access targets the row most recently activated in its bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid_i | input | 1 | A request is offered |
| enq_write_i | input | 1 | 1 for write, 0 for read |
| enq_id_i | input | ID_W | Transaction ID |
| enq_bank_i | input | log2(BANKS) | Target bank |
| enq_row_i | input | ROW_W | Target row |
| enq_col_i | input | COL_W | Target column |
| enq_ready_o | output | 1 | Pool can take a request this cycle |
| cmd_valid_o | output | 1 | A DRAM command is issued |
| cmd_op_o | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank_o | output | log2(BANKS) | Command bank |
| cmd_row_o | output | ROW_W | Command row |
| cmd_col_o | output | COL_W | Command column (accesses) |
| cpl_valid_o | output | 1 | A request completes |
| cpl_id_o | output | ID_W | ID of the completing request |
| cpl_write_o | output | 1 | Direction of the completing request |

## Verification
The assertions assume that the bank count is a power of two, so every bank index offered by the requester names a real bank. They also assume that request fields are only meaningful while `enq_valid_i` is high. The bench keeps to this: it uses two banks and drives every field together with `enq_valid_i`. It also holds an offered request until `enq_ready_o` admits it, except in the one deliberate refusal case, where it withdraws the request after a single refused cycle. Timing checks compare command spacing against T_RP and T_RCD, using a bank model built only from the commands seen on the output.

// File: rtl/rowhit_pkg.sv
package rowhit_pkg;
  typedef enum logic [1:0] {
    OP_PRE = 2'd0,
    OP_ACT = 2'd1,
    OP_RD  = 2'd2,
    OP_WR  = 2'd3
  } dram_op_e;
endpackage

// File: rtl/rowhit_bank.sv
module rowhit_bank #(
  parameter int ROW_W = 3,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pre_i,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             acc_ok_o
);
  localparam int TMAX = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int TW   = $clog2(TMAX + 1);

  logic          open_q;
  logic [ROW_W-1:0] row_q;
  logic [TW-1:0] rp_q, rcd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rp_q   <= '0;
      rcd_q  <= '0;
    end else begin
      if (rp_q != '0)  rp_q  <= rp_q - 1'b1;
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= TW'(T_RP - 1);
      end else if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= TW'(T_RCD - 1);
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign act_ok_o = (rp_q == '0);
  assign acc_ok_o = (rcd_q == '0);

  assert_pre_open_R9: assert property (@(posedge clk) disable iff (rst)
    pre_i |-> open_q);
  assert_act_closed_R2: assert property (@(posedge clk) disable iff (rst)
    act_i |-> (!open_q && !pre_i));
endmodule

// File: rtl/rowhit_pick.sv
module rowhit_pick #(
  parameter int DEPTH   = 4,
  parameter int BANKS   = 2,
  parameter int BANK_W  = 1,
  parameter int ID_W    = 2,
  parameter int ROW_W   = 3,
  parameter int AGE_W   = 2,
  parameter int AGE_MAX = 3,
  parameter int IW      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  vld_i,
  input  logic [ID_W-1:0]   id_i   [DEPTH],
  input  logic [BANK_W-1:0] bank_i [DEPTH],
  input  logic [ROW_W-1:0]  row_i  [DEPTH],
  input  logic [AGE_W-1:0]  age0_i,
  input  logic [BANKS-1:0]  open_i,
  input  logic [ROW_W-1:0]  orow_i [BANKS],
  input  logic [BANKS-1:0]  act_ok_i,
  input  logic [BANKS-1:0]  acc_ok_i,
  output logic              go_o,
  output logic [IW-1:0]     idx_o,
  output logic              access_o,
  output logic              act_o
);
  logic             force_old;
  logic [DEPTH-1:0] elig, owner, hit, prep;

  always_comb begin
    force_old = vld_i[0] && (age0_i >= AGE_W'(AGE_MAX));
    for (int i = 0; i < DEPTH; i++) begin
      elig[i]  = vld_i[i] && (!force_old || i == 0);
      owner[i] = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (vld_i[j] && id_i[j] == id_i[i])     elig[i]  = 1'b0;
        if (vld_i[j] && bank_i[j] == bank_i[i]) owner[i] = 1'b0;
      end
      hit[i]  = elig[i] && open_i[bank_i[i]] &&
                (orow_i[bank_i[i]] == row_i[i]) && acc_ok_i[bank_i[i]];
      prep[i] = elig[i] && owner[i] &&
                (open_i[bank_i[i]] ? (orow_i[bank_i[i]] != row_i[i])
                                   : act_ok_i[bank_i[i]]);
    end
    go_o     = 1'b0;
    access_o = 1'b0;
    idx_o    = '0;
    // preparation candidates first, hits override; lowest index wins each pass
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (prep[i]) begin
        go_o  = 1'b1;
        idx_o = IW'(i);
      end
    end
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        go_o     = 1'b1;
        access_o = 1'b1;
        idx_o    = IW'(i);
      end
    end
    act_o = !open_i[bank_i[idx_o]];
  end

  assert_forced_oldest_R7: assert property (@(posedge clk) disable iff (rst)
    (vld_i[0] && age0_i >= AGE_W'(AGE_MAX) && go_o) |-> (idx_o == '0));
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import rowhit_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int BANKS   = 2,
  parameter int ID_W    = 2,
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int AGE_MAX = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enq_valid_i,
  input  logic                     enq_write_i,
  input  logic [ID_W-1:0]          enq_id_i,
  input  logic [$clog2(BANKS)-1:0] enq_bank_i,
  input  logic [ROW_W-1:0]         enq_row_i,
  input  logic [COL_W-1:0]         enq_col_i,
  output logic                     enq_ready_o,
  output logic                     cmd_valid_o,
  output logic [1:0]               cmd_op_o,
  output logic [$clog2(BANKS)-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]         cmd_row_o,
  output logic [COL_W-1:0]         cmd_col_o,
  output logic                     cpl_valid_o,
  output logic [ID_W-1:0]          cpl_id_o,
  output logic                     cpl_write_o
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int AGE_W  = $clog2(AGE_MAX + 1);
  localparam int IW     = $clog2(DEPTH);

  // request pool, index 0 is the oldest entry
  logic [DEPTH-1:0]  v_q, v_d, wr_q, wr_d;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [ID_W-1:0]   id_d   [DEPTH];
  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [BANK_W-1:0] bank_d [DEPTH];
  logic [ROW_W-1:0]  row_q  [DEPTH];
  logic [ROW_W-1:0]  row_d  [DEPTH];
  logic [COL_W-1:0]  col_q  [DEPTH];
  logic [COL_W-1:0]  col_d  [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];
  logic [AGE_W-1:0]  age_d  [DEPTH];

  logic [BANKS-1:0] open_b, act_ok_b, acc_ok_b, pre_b, act_b;
  logic [ROW_W-1:0] orow_b [BANKS];

  logic          go, access, act;
  logic [IW-1:0] idx;
  logic          rm, enq_ok;

  assign enq_ready_o = !v_q[DEPTH-1];
  assign enq_ok      = enq_valid_i && !v_q[DEPTH-1];
  assign rm          = go && access;

  rowhit_pick #(
    .DEPTH(DEPTH), .BANKS(BANKS), .BANK_W(BANK_W), .ID_W(ID_W),
    .ROW_W(ROW_W), .AGE_W(AGE_W), .AGE_MAX(AGE_MAX), .IW(IW)
  ) u_pick (
    .clk(clk), .rst(rst), .vld_i(v_q), .id_i(id_q), .bank_i(bank_q),
    .row_i(row_q), .age0_i(age_q[0]), .open_i(open_b), .orow_i(orow_b),
    .act_ok_i(act_ok_b), .acc_ok_i(acc_ok_b),
    .go_o(go), .idx_o(idx), .access_o(access), .act_o(act)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    assign pre_b[g] = go && !access && !act && (bank_q[idx] == BANK_W'(g));
    assign act_b[g] = go && !access &&  act && (bank_q[idx] == BANK_W'(g));
    rowhit_bank #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)) u_bank (
      .clk(clk), .rst(rst), .pre_i(pre_b[g]), .act_i(act_b[g]),
      .row_i(row_q[idx]), .open_o(open_b[g]), .row_o(orow_b[g]),
      .act_ok_o(act_ok_b[g]), .acc_ok_o(acc_ok_b[g])
    );
  end

  always_comb begin
    int pos;
    pos = $countones(v_q) - (rm ? 1 : 0);
    v_d  = '0;
    wr_d = '0;
    for (int i = 0; i < DEPTH; i++) begin
      int s;
      s = (rm && i >= int'(idx)) ? i + 1 : i;
      id_d[i] = '0; bank_d[i] = '0; row_d[i] = '0; col_d[i] = '0; age_d[i] = '0;
      if (s < DEPTH) begin
        v_d[i]    = v_q[s];
        wr_d[i]   = wr_q[s];
        id_d[i]   = id_q[s];
        bank_d[i] = bank_q[s];
        row_d[i]  = row_q[s];
        col_d[i]  = col_q[s];
        age_d[i]  = age_q[s];
        if (rm && i < int'(idx) && age_q[i] < AGE_W'(AGE_MAX))
          age_d[i] = age_q[i] + 1'b1;
      end
      if (enq_ok && i == pos) begin
        v_d[i]    = 1'b1;
        wr_d[i]   = enq_write_i;
        id_d[i]   = enq_id_i;
        bank_d[i] = enq_bank_i;
        row_d[i]  = enq_row_i;
        col_d[i]  = enq_col_i;
        age_d[i]  = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      v_q <= v_d;
    end
    wr_q <= wr_d;
    for (int i = 0; i < DEPTH; i++) begin
      id_q[i]   <= id_d[i];
      bank_q[i] <= bank_d[i];
      row_q[i]  <= row_d[i];
      col_q[i]  <= col_d[i];
      age_q[i]  <= rst ? '0 : age_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_o <= 1'b0;
      cmd_op_o    <= '0;
      cmd_bank_o  <= '0;
      cmd_row_o   <= '0;
      cmd_col_o   <= '0;
      cpl_valid_o <= 1'b0;
      cpl_id_o    <= '0;
      cpl_write_o <= 1'b0;
    end else begin
      cmd_valid_o <= go;
      if (access) cmd_op_o <= wr_q[idx] ? OP_WR : OP_RD;
      else        cmd_op_o <= act ? OP_ACT : OP_PRE;
      cmd_bank_o  <= bank_q[idx];
      cmd_row_o   <= row_q[idx];
      cmd_col_o   <= col_q[idx];
      cpl_valid_o <= rm;
      cpl_id_o    <= id_q[idx];
      cpl_write_o <= wr_q[idx];
    end
  end

  assert_access_open_row_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_o && cmd_op_o[1]) |-> (open_b[cmd_bank_o] && orow_b[cmd_bank_o] == cmd_row_o));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (v_q[DEPTH-1] && !rm) |=> v_q[DEPTH-1]);
endmodule

// File: tb/rowhit_sched_tb.sv
module rowhit_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, BANKS = 2, ID_W = 2, ROW_W = 3, COL_W = 3;
  localparam int T_RP = 2, T_RCD = 2, AGE_MAX = 3;

  typedef struct packed {
    logic [31:0]      seq;
    logic [ID_W-1:0]  id;
    logic             w;
    logic             b;
    logic [ROW_W-1:0] r;
    logic [COL_W-1:0] c;
  } req_t;

  logic clk = 0, rst = 1;
  logic enq_valid = 0, enq_write = 0;
  logic [ID_W-1:0] enq_id = 0;
  logic enq_bank = 0;
  logic [ROW_W-1:0] enq_row = 0;
  logic [COL_W-1:0] enq_col = 0;
  logic enq_ready, cmd_valid, cpl_valid, cpl_write;
  logic [1:0] cmd_op;
  logic cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [ID_W-1:0] cpl_id;

  rowhit_sched u_dut (
    .clk(clk), .rst(rst), .enq_valid_i(enq_valid), .enq_write_i(enq_write),
    .enq_id_i(enq_id), .enq_bank_i(enq_bank), .enq_row_i(enq_row),
    .enq_col_i(enq_col), .enq_ready_o(enq_ready), .cmd_valid_o(cmd_valid),
    .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row),
    .cmd_col_o(cmd_col), .cpl_valid_o(cpl_valid), .cpl_id_o(cpl_id),
    .cpl_write_o(cpl_write)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, seq_n = 0;
  bit done = 0;
  req_t pend[$];
  int log_op [0:511];
  int log_bank [0:511];
  int nlog = 0;
  int cpl_seq [0:511];
  int ncpl = 0;
  bit m_open [2];
  int m_row [2];
  int m_pre [2];
  int m_act [2];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor: bank model from observed commands, completion order model
  always @(negedge clk) if (!rst) begin
    if (cmd_valid) begin
      log_op[nlog] = int'(cmd_op); log_bank[nlog] = int'(cmd_bank); nlog++;
      case (cmd_op)
        2'd0: begin
          chk(m_open[cmd_bank], "R9 precharge to open bank", 0, 1);
          m_open[cmd_bank] = 0; m_pre[cmd_bank] = cyc;
        end
        2'd1: begin
          chk(!m_open[cmd_bank], "R2 activate to closed bank", 1, 0);
          chk(cyc - m_pre[cmd_bank] >= T_RP, "R2 precharge-to-activate gap",
              cyc - m_pre[cmd_bank], T_RP);
          m_open[cmd_bank] = 1; m_row[cmd_bank] = int'(cmd_row); m_act[cmd_bank] = cyc;
        end
        default: begin
          chk(m_open[cmd_bank] && m_row[cmd_bank] == int'(cmd_row),
              "R9 access row open", int'(cmd_row), m_row[cmd_bank]);
          chk(cyc - m_act[cmd_bank] >= T_RCD, "R2 activate-to-access gap",
              cyc - m_act[cmd_bank], T_RCD);
          chk(cpl_valid == 1'b1, "R5 completion with access", int'(cpl_valid), 1);
          begin
            int k;
            k = -1;
            for (int q = 0; q < pend.size(); q++)
              if (k < 0 && pend[q].id == cpl_id) k = q;
            chk(k >= 0, "R6 completion id pending", int'(cpl_id), -1);
            if (k >= 0) begin
              chk(pend[k].b == cmd_bank && pend[k].r == cmd_row && pend[k].c == cmd_col &&
                  pend[k].w == cmd_op[0] && cpl_write == pend[k].w,
                  "R6 same-id order fields", int'(cmd_col), int'(pend[k].c));
              cpl_seq[ncpl] = int'(pend[k].seq); ncpl++;
              pend.delete(k);
            end
          end
        end
      endcase
    end
    if (!(cmd_valid && cmd_op[1]))
      chk(!cpl_valid, "R5 no stray completion", int'(cpl_valid), 0);
  end

  task automatic enq(input bit w, input int id, input int b, input int r, input int c);
    req_t e;
    @(negedge clk);
    enq_valid = 1; enq_write = w; enq_id = ID_W'(id); enq_bank = b[0];
    enq_row = ROW_W'(r); enq_col = COL_W'(c);
    while (!enq_ready) @(negedge clk);
    @(posedge clk);
    e.seq = 32'(seq_n); e.id = ID_W'(id); e.w = w; e.b = b[0];
    e.r = ROW_W'(r); e.c = COL_W'(c);
    pend.push_back(e);
    seq_n++;
  endtask

  task automatic idle();
    @(negedge clk);
    enq_valid = 0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (pend.size() != 0 && t < 400) begin
      @(negedge clk); t++;
    end
    chk(pend.size() == 0, "R6 all requests completed", pend.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (DEPTH * 100000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int s, c0, base, mseq, young;
    for (int b = 0; b < 2; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_pre[b] = -100; m_act[b] = -100;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    repeat (2) @(negedge clk);
    // R8 reset state
    chk(enq_ready == 1, "R8 ready after reset", int'(enq_ready), 1);
    chk(cmd_valid == 0, "R8 no command after reset", int'(cmd_valid), 0);
    chk(cpl_valid == 0, "R8 no completion after reset", int'(cpl_valid), 0);

    // R2 closed-bank miss: activate then read
    s = nlog;
    enq(0, 0, 0, 1, 2); idle(); drain();
    chk(nlog - s == 2, "R2 command count", nlog - s, 2);
    chk(log_op[s] == 1 && log_op[s+1] == 2, "R2 activate then read",
        log_op[s] * 10 + log_op[s+1], 12);

    // R1 open-row hit: read only
    s = nlog;
    enq(0, 1, 0, 1, 5); idle(); drain();
    chk(nlog - s == 1 && log_op[s] == 2, "R1 hit served by access only",
        nlog - s, 1);

    // R4 bank overlap: bank0 miss (open row 1) and bank1 closed
    s = nlog; c0 = ncpl; base = seq_n;
    enq(0, 0, 0, 3, 1); enq(1, 1, 1, 5, 2); idle(); drain();
    chk(nlog - s == 5, "R4 command count", nlog - s, 5);
    chk(log_op[s] == 0 && log_bank[s] == 0, "R4 precharge bank0 first",
        log_op[s] * 10 + log_bank[s], 0);
    chk(log_op[s+1] == 1 && log_bank[s+1] == 1, "R4 bank1 activate overlaps bank0 wait",
        log_op[s+1] * 10 + log_bank[s+1], 11);
    chk(log_op[s+2] == 1 && log_bank[s+2] == 0, "R2 bank0 activate after wait",
        log_op[s+2] * 10 + log_bank[s+2], 10);
    chk(log_op[s+3] == 3 && log_bank[s+3] == 1, "R5 write to bank1 completes first",
        log_op[s+3] * 10 + log_bank[s+3], 31);
    chk(cpl_seq[c0] == base + 1, "R5 out-of-order completion", cpl_seq[c0], base + 1);

    // R6 same-id ordering with an interleaved different-id hit
    c0 = ncpl; base = seq_n;
    enq(0, 0, 1, 6, 3); enq(0, 0, 0, 4, 4); enq(1, 1, 0, 3, 6); idle(); drain();
    chk(cpl_seq[c0] == base + 2, "R3 hit served before older misses", cpl_seq[c0], base + 2);
    chk(cpl_seq[c0+1] == base, "R6 older same-id first", cpl_seq[c0+1], base);
    chk(cpl_seq[c0+2] == base + 1, "R6 younger same-id last", cpl_seq[c0+2], base + 1);

    // R7 bypass cap: a miss surrounded by a stream of hits to bank0 row 2
    c0 = ncpl; base = seq_n;
    enq(0, 1, 0, 2, 0); enq(0, 2, 0, 2, 1);
    mseq = seq_n; enq(0, 0, 0, 7, 2);
    for (int h = 0; h < 7; h++) enq(h[0], (h % 3) + 1, 0, 2, 3 + (h % 5));
    idle(); drain();
    young = 0;
    for (int k = c0; k < ncpl; k++) begin
      if (cpl_seq[k] == mseq) break;
      if (cpl_seq[k] > mseq) young++;
    end
    chk(young == AGE_MAX, "R7 bypass count of starved miss", young, AGE_MAX);
    begin
      int ordered;
      int last;
      ordered = 1; last = -1;
      for (int k = c0; k < c0 + 6; k++) begin
        if (cpl_seq[k] != mseq) begin
          if (cpl_seq[k] < last) ordered = 0;
          last = cpl_seq[k];
        end
      end
      chk(ordered == 1, "R3 hits served oldest first", ordered, 1);
    end

    // R8 full pool refuses a request (bank1 open on row 6)
    c0 = ncpl;
    enq(0, 0, 1, 0, 0); enq(0, 0, 1, 1, 1); enq(0, 0, 1, 2, 2); enq(0, 0, 1, 3, 3);
    @(negedge clk);
    chk(enq_ready == 0, "R8 ready low when full", int'(enq_ready), 0);
    enq_valid = 1; enq_id = 3; enq_bank = 1; enq_row = 5; enq_col = 7;
    @(negedge clk);
    enq_valid = 0;
    drain();
    chk(ncpl - c0 == 4, "R8 refused request never completes", ncpl - c0, 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule